// File: doc/BRIEF.md
# Floating-Point Move Overlap Classifier

This block sits at the issue point of a floating-point unit. For every operation offered there, it produces a 2-bit grade. The grade says how far that operation may overlap the one issued just before it: fully, partially, or not at all. The grade is decided by several things together. These are the operation kind and operand format, register reuse against the previous destination, the class of the operand value, the rounding-precision setting, the inexact trap enable and a range-fault flag. A register hazard alone does not decide it. The block does not execute anything.

Operations arrive as a valid/ready stream and leave as a valid/ready stream, with the grade attached and no storage in the path. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. When the consumer holds `out_ready` low, the offered operation is not accepted and the classifier keeps its state. The operation must stay on the inputs until a cycle in which both valid and ready are high. Only such an accepted operation updates the record of the last destination register.

Top module: `fpc_overlap_top`

## Requirements
- R1: `out_level` is 2'b00 for none, 2'b01 for partial and 2'b10 for full, and never 2'b11. Every rule below gives a cap, and the grade is the lowest of these caps; with no cap the grade is full.
- R2: Operation kinds are 0 reg-to-reg move, 1 mem-to-reg move, 2 reg-to-mem move, 3 control-register move, 4 constant load, 5 multi-register move, 6 arithmetic, 7 test. Formats are 0 byte, 1 word, 2 long, 3 single, 4 double, 5 extended, 6 packed decimal, 7 reserved. Kinds 3, 4 and 5, and formats 0, 1, 2, 6 and 7, give the grade none.
- R3: A move of kind 0 or 2 whose `in_src` equals the valid recorded destination gets the grade none.
- R4: A move of kind 0 or 1 whose `in_dst` equals the valid recorded destination gets the grade none.
- R5: `in_special` set (NaN, unnormalized or denormal operand) caps the grade at partial.
- R6: For kinds 0 and 1, a `rnd_prec` value other than 0 (0 means extended; any other value reduces precision) caps the grade at partial.
- R7: For kind 2 with format 3 or 4, a set `inex_trap_en` or a set `ovf_unf` caps the grade at partial.
- R8: For kind 2 with format 5, neither `rnd_prec`, `inex_trap_en` nor `ovf_unf` changes the grade.
- R9: Kinds 6 and 7 with format 3, 4 or 5 get partial.
- R10: The recorded destination is invalid after reset. Each accepted operation of kind 0, 1, 4 or 6 loads its `in_dst`, and any other accepted operation clears the record. A cycle with `in_valid` or `out_ready` low leaves the record unchanged.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_kind | input | 3 | Operation kind code |
| in_fmt | input | 3 | Operand format code |
| in_src | input | 3 | Source register number |
| in_dst | input | 3 | Destination register number |
| in_special | input | 1 | Operand is NaN, unnormalized or denormal |
| rnd_prec | input | 2 | Rounding-precision setting |
| inex_trap_en | input | 1 | Inexact trap enabled |
| ovf_unf | input | 1 | Overflow or underflow indicated |
| out_valid | output | 1 | Grade valid |
| out_ready | input | 1 | Consumer takes the grade |
| out_level | output | 2 | Overlap grade |

## Verification
A register conflict against the recorded destination and the cap from the operand value or mode bits can apply to the same operation. The bench primes the record with one accepted operation. The next cycle it offers every kind, format and flag setting with the source matching, the destination matching, both matching or neither matching. A reference grade is computed as the minimum of the caps. The bench also checks that the conflict result, none, wins over any partial cap. A second overlap is a stalled cycle that would have rewritten the record. It is checked by showing that the earlier destination still conflicts once the stall ends.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int REG_W = 3;
  localparam int LVL_W = 2;

  typedef enum logic [2:0] {
    K_MOV_RR = 3'd0, K_MOV_MR = 3'd1, K_MOV_RM = 3'd2, K_MOV_CTL = 3'd3,
    K_CONST  = 3'd4, K_MULTI  = 3'd5, K_ARITH  = 3'd6, K_TEST    = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    F_BYTE = 3'd0, F_WORD = 3'd1, F_LONG = 3'd2, F_SGL = 3'd3,
    F_DBL  = 3'd4, F_EXT  = 3'd5, F_PACK = 3'd6, F_RSV = 3'd7
  } fmt_e;

  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'b00, LVL_PART = 2'b01, LVL_FULL = 2'b10
  } level_e;

  typedef struct packed {
    logic minimal;
    logic nonmove_fp;
    logic reads_src;
    logic dst_check;
    logic writes_reg;
    logic to_reg;
    logic to_mem_sd;
  } decode_t;
endpackage

// File: rtl/fpc_op_decode.sv
module fpc_op_decode
  import fpc_pkg::*;
(
  input  logic [2:0] kind,
  input  logic [2:0] fmt,
  output decode_t    dec
);
  logic fp_fmt;
  always_comb begin
    fp_fmt = (fmt == F_SGL) || (fmt == F_DBL) || (fmt == F_EXT);
    dec.minimal    = !fp_fmt || (kind == K_MOV_CTL) || (kind == K_CONST) ||
                     (kind == K_MULTI);
    dec.nonmove_fp = fp_fmt && ((kind == K_ARITH) || (kind == K_TEST));
    dec.reads_src  = (kind == K_MOV_RR) || (kind == K_MOV_RM);
    dec.dst_check  = (kind == K_MOV_RR) || (kind == K_MOV_MR);
    dec.writes_reg = (kind == K_MOV_RR) || (kind == K_MOV_MR) ||
                     (kind == K_CONST)  || (kind == K_ARITH);
    dec.to_reg     = (kind == K_MOV_RR) || (kind == K_MOV_MR);
    dec.to_mem_sd  = (kind == K_MOV_RM) && ((fmt == F_SGL) || (fmt == F_DBL));
  end
endmodule

// File: rtl/fpc_dst_tracker.sv
module fpc_dst_tracker #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             writes_reg,
  input  logic [REG_W-1:0] dst,
  output logic             prev_valid,
  output logic [REG_W-1:0] prev_dst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_dst   <= '0;
    end else if (accept) begin
      prev_valid <= writes_reg;
      if (writes_reg) prev_dst <= dst;
    end
  end
endmodule

// File: rtl/fpc_level_merge.sv
module fpc_level_merge #(
  parameter int NUM_CAPS = 7,
  parameter int LVL_W    = 2
) (
  input  logic [NUM_CAPS-1:0][LVL_W-1:0] caps,
  output logic [LVL_W-1:0]               level
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(2);
  logic [NUM_CAPS:0][LVL_W-1:0] chain;
  assign chain[0] = TOP;
  for (genvar i = 0; i < NUM_CAPS; i++) begin : g_min
    assign chain[i+1] = (caps[i] < chain[i]) ? caps[i] : chain[i];
  end
  assign level = chain[NUM_CAPS];
endmodule

// File: rtl/fpc_overlap_top.sv
module fpc_overlap_top
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [2:0] in_kind,
  input  logic [2:0] in_fmt,
  input  logic [2:0] in_src,
  input  logic [2:0] in_dst,
  input  logic       in_special,
  input  logic [1:0] rnd_prec,
  input  logic       inex_trap_en,
  input  logic       ovf_unf,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_level
);
  localparam int NUM_CAPS = 7;

  decode_t             dec;
  logic                accept;
  logic                prev_valid;
  logic [REG_W-1:0]    prev_dst;
  logic                src_hit, dst_hit;
  logic [NUM_CAPS-1:0][LVL_W-1:0] caps;

  fpc_op_decode u_dec (.kind(in_kind), .fmt(in_fmt), .dec(dec));

  assign accept = in_valid && out_ready;

  fpc_dst_tracker #(.REG_W(REG_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .writes_reg(dec.writes_reg),
    .dst(in_dst), .prev_valid(prev_valid), .prev_dst(prev_dst)
  );

  always_comb begin
    src_hit = dec.reads_src && prev_valid && (in_src == prev_dst);
    dst_hit = dec.dst_check && prev_valid && (in_dst == prev_dst);
    caps[0] = dec.minimal    ? LVL_NONE : LVL_FULL;
    caps[1] = dec.nonmove_fp ? LVL_PART : LVL_FULL;
    caps[2] = src_hit        ? LVL_NONE : LVL_FULL;
    caps[3] = dst_hit        ? LVL_NONE : LVL_FULL;
    caps[4] = in_special     ? LVL_PART : LVL_FULL;
    caps[5] = (dec.to_reg && (rnd_prec != 2'd0)) ? LVL_PART : LVL_FULL;
    caps[6] = (dec.to_mem_sd && (inex_trap_en || ovf_unf)) ? LVL_PART : LVL_FULL;
  end

  fpc_level_merge #(.NUM_CAPS(NUM_CAPS), .LVL_W(LVL_W)) u_merge (
    .caps(caps), .level(out_level)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/fpc_overlap_chk.sv
module fpc_overlap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_kind,
  input logic [2:0] in_fmt,
  input logic [2:0] in_src,
  input logic [2:0] in_dst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_level
);
  logic acc, wr;
  assign acc = in_valid && out_ready;
  assign wr  = (in_kind == 3'd0) || (in_kind == 3'd1) || (in_kind == 3'd4) ||
               (in_kind == 3'd6);

  // R1
  level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_level != 2'b11);

  // R2
  min_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fmt <= 3'd2 || in_fmt >= 3'd6) |-> out_level == 2'b00);

  // R3
  src_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr) |=> ((in_kind == 3'd0 || in_kind == 3'd2) &&
                     in_src == $past(in_dst)) |-> out_level == 2'b00);

  // R4
  dst_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr) |=> ((in_kind == 3'd0 || in_kind == 3'd1) &&
                     in_dst == $past(in_dst)) |-> out_level == 2'b00);

  // R9
  nonmove_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_kind >= 3'd6 && in_fmt >= 3'd3 && in_fmt <= 3'd5) |-> out_level == 2'b01);

  // R11
  stream_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));
endmodule

bind fpc_overlap_top fpc_overlap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .in_fmt(in_fmt), .in_src(in_src), .in_dst(in_dst),
  .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level)
);

// File: tb/fpc_overlap_top_tb.sv
module fpc_overlap_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [2:0] in_kind = '0, in_fmt = '0, in_src = '0, in_dst = '0;
  logic in_special = 1'b0, inex_trap_en = 1'b0, ovf_unf = 1'b0;
  logic [1:0] rnd_prec = '0, out_level;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpc_overlap_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_fmt(in_fmt), .in_src(in_src), .in_dst(in_dst),
    .in_special(in_special), .rnd_prec(rnd_prec), .inex_trap_en(inex_trap_en),
    .ovf_unf(ovf_unf), .out_valid(out_valid), .out_ready(out_ready),
    .out_level(out_level)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b kind=%0d fmt=%0d src=%0d dst=%0d",
               req, act, exp, in_kind, in_fmt, in_src, in_dst);
    end
  endtask

  task automatic drive(input int k, input int f, input int s, input int d,
                       input bit sp, input int pr, input bit ie, input bit ou);
    in_kind = 3'(k); in_fmt = 3'(f); in_src = 3'(s); in_dst = 3'(d);
    in_special = sp; rnd_prec = 2'(pr); inex_trap_en = ie; ovf_unf = ou;
  endtask

  // Reference grade: minimum of caps, plus the requirement that decides it.
  function automatic logic [1:0] model(input int k, input int f, input bit pv,
      input bit sm, input bit dm, input bit sp, input int pr, input bit ie,
      input bit ou, output string tag);
    bit fp = (f >= 3 && f <= 5);
    logic [1:0] lv = 2'b10;
    tag = "R1";
    if (!fp || k == 3 || k == 4 || k == 5) begin tag = "R2"; return 2'b00; end
    if (k >= 6) begin tag = "R9"; return 2'b01; end
    if (pv && sm && (k == 0 || k == 2)) begin tag = "R3"; return 2'b00; end
    if (pv && dm && (k == 0 || k == 1)) begin tag = "R4"; return 2'b00; end
    if (sp) begin tag = "R5"; lv = 2'b01; end
    else if ((k == 0 || k == 1) && pr != 0) begin tag = "R6"; lv = 2'b01; end
    else if (k == 2 && f != 5 && (ie || ou)) begin tag = "R7"; lv = 2'b01; end
    else if (k == 2 && f == 5 && (pr != 0 || ie || ou)) tag = "R8";
    return lv;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [1:0] exp;
    repeat (3) @(negedge clk);
    // R10: after reset the record is invalid, so a self-overlapping move is full
    in_valid = 1'b1;
    drive(0, 5, 0, 0, 0, 0, 0, 0);
    #1 check("R10 reset", out_level, 2'b10);
    rst_n = 1'b1;

    // Sweep: prime the record, then classify the next operation.
    for (int pv = 0; pv < 2; pv++)
      for (int cs = 0; cs < 4; cs++)
        for (int k = 0; k < 8; k++)
          for (int f = 0; f < 8; f++)
            for (int m = 0; m < 32; m++) begin
              bit sp = m[0], ie = m[1], ou = m[2];
              int pr = (m >> 3) & 3;
              @(negedge clk);
              if (pv) drive(6, 5, 1, 5, 0, 0, 0, 0);
              else    drive(7, 5, 1, 5, 0, 0, 0, 0);
              @(negedge clk);
              drive(k, f, cs[0] ? 5 : 2, cs[1] ? 5 : 3, sp, pr, ie, ou);
              exp = model(k, f, pv[0], cs[0], cs[1], sp, pr, ie, ou, tag);
              #1 check(tag, out_level, exp);
            end

    // R10: stalled cycle must not rewrite the record
    @(negedge clk);
    drive(0, 5, 1, 4, 0, 0, 0, 0);           // accepted, records 4
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 5, 0, 6, 0, 0, 0, 0);           // stalled, would record 6
    #1 check("R11 ready", {1'b0, in_ready}, 2'b00);
    check("R11 valid", {1'b0, out_valid}, 2'b01);
    @(negedge clk);
    out_ready = 1'b1;
    drive(1, 5, 0, 4, 0, 0, 0, 0);
    #1 check("R10 stall keeps record", out_level, 2'b00);
    @(negedge clk);                           // accepted, records 4 again
    in_valid = 1'b0;
    drive(1, 5, 0, 6, 0, 0, 0, 0);           // idle, would record 6
    #1 check("R11 valid low", {1'b0, out_valid}, 2'b00);
    @(negedge clk);
    in_valid = 1'b1;
    drive(1, 5, 0, 4, 0, 0, 0, 0);
    #1 check("R10 idle keeps record", out_level, 2'b00);
    @(negedge clk);                           // accepted
    drive(2, 5, 4, 0, 0, 0, 0, 0);           // to memory, clears record
    #1 check("R3 mem store conflict", out_level, 2'b00);
    @(negedge clk);
    drive(1, 5, 0, 4, 0, 0, 0, 0);
    #1 check("R10 store clears record", out_level, 2'b10);
    check("R11 ready high", {1'b0, in_ready}, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule